// File: doc/BRIEF.md
# Nibble-Stack Subroutine Controller

This block owns the stack pointer of a 4-bit microcontroller whose stack sits in a nibble-wide RAM. It carries out the stack side of six instructions: subroutine call, plain return, return that skips the next instruction, return from interrupt, register-pair push and register-pair pop. Instruction decode presents one command together with the operands it needs: the call target, the return address to save and the register pair. The block then runs the required nibble writes or reads on the RAM port, one access per cycle, and adjusts the stack pointer. At the end it reports the new program counter, the restored register pair or status word, and a skip request, all on registered outputs.

An 11-bit program counter is saved as four nibbles. These nibbles do not sit at consecutive addresses. The top three PC bits go to the slot furthest from the pointer, with a zero bit above them. The middle and low nibbles go to the two slots just below the pointer. The slot between them holds a zero pad nibble. A return reads the same slots back in the mirrored positions. A return from interrupt also fetches an 8-bit status word from the two nibbles above the saved address.

Top module: `nstk_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sp_out` equals `SP_INIT`. In that cycle `busy`, `done`, `pc_load`, `rp_load`, `psw_load`, `skip` and `mem_we` are all 0.
- R2: The command is accepted when `cmd_valid` is 1 and `busy` is 0. The `cmd_op` codes are: 1 call, 2 return, 3 return-and-skip, 4 return-from-interrupt, 5 push, 6 pop. Codes 0 and 7 have no effect.
- R3: A call writes four nibbles at the rate of one per busy cycle, in this order: PC[7:4] to SP-1, PC[3:0] to SP-2, 0 to SP-3, and {0, PC[10:8]} to SP-4. It then pulses `pc_load` with `pc_out` equal to `cmd_target`, and SP drops by 4.
- R4: A return reads the RAM at SP, SP+3 and SP+2 and loads `pc_out` = {mem[SP][2:0], mem[SP+3], mem[SP+2]}. Bit 3 of mem[SP] is ignored. SP rises by 4 and `skip` stays 0.
- R5: Return-and-skip restores the PC and SP exactly as R4 does, and also pulses `skip` together with `pc_load`.
- R6: Return-from-interrupt restores the PC as R4 does. It also loads `psw_out` = {mem[SP+4], mem[SP+5]} with a `psw_load` pulse, and raises SP by 6.
- R7: A push writes `rp_in[7:4]` to SP-1, then `rp_in[3:0]` to SP-2, and lowers SP by 2. It loads no PC, register pair or status word.
- R8: A pop loads `rp_out` = {mem[SP+1], mem[SP]} with an `rp_load` pulse and raises SP by 2.
- R9: SP is an AW-bit value that wraps modulo 2^AW in both directions. All stack addresses wrap the same way.
- R10: `busy` rises in the cycle after acceptance. It stays high for N cycles on a write command and N+1 cycles on a read command, where N is the nibble count: call 4, push 2, return 3, return-and-skip 3, return-from-interrupt 5, pop 2. `done` pulses for one cycle as `busy` falls, and commands offered while busy are ignored.
- R11: `mem_we` is high only during the busy cycles of a call or push. The RAM returns read data one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_target | input | 11 | Call destination |
| cur_pc | input | 11 | Return address saved by a call |
| rp_in | input | 8 | Register pair saved by a push |
| mem_addr | output | AW | Stack RAM address |
| mem_we | output | 1 | Stack RAM write enable |
| mem_wdata | output | 4 | Stack RAM write nibble |
| mem_rdata | input | 4 | Stack RAM read nibble, one cycle latency |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | AW | Current stack pointer |
| pc_out | output | 11 | New program counter |
| pc_load | output | 1 | `pc_out` is valid this cycle |
| skip | output | 1 | Skip the next instruction |
| rp_out | output | 8 | Restored register pair |
| rp_load | output | 1 | `rp_out` is valid this cycle |
| psw_out | output | 8 | Restored status word |
| psw_load | output | 1 | `psw_out` is valid this cycle |

## Verification
A stack pointer that is off by even one slot does not corrupt the result of the command that causes it. The fault shows up later, when the next return or pop rebuilds a PC or register pair from the wrong nibbles. For that reason every command in the bench is followed by the matching restore, so that such a fault surfaces within a few commands. A step counter or slot-order fault does show at once: it writes to the wrong address or stretches `busy` beyond its N or N+1 cycles, and the bench compares both against its own RAM model when `done` appears.

// File: rtl/nstk_pkg.sv
package nstk_pkg;
  localparam int NIB_W     = 4;
  localparam int PC_W      = 11;
  localparam int MAX_SLOTS = 5;
  localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_CALL = 3'd1,
    OP_RET  = 3'd2,
    OP_RETS = 3'd3,
    OP_RETI = 3'd4,
    OP_PUSH = 3'd5,
    OP_POP  = 3'd6
  } op_e;

  // number of nibble accesses a command needs; zero means not a command
  function automatic logic [SLOT_W-1:0] op_steps(op_e op);
    case (op)
      OP_CALL:          return SLOT_W'(4);
      OP_RET, OP_RETS:  return SLOT_W'(3);
      OP_RETI:          return SLOT_W'(5);
      OP_PUSH, OP_POP:  return SLOT_W'(2);
      default:          return '0;
    endcase
  endfunction

  function automatic logic op_is_write(op_e op);
    return (op == OP_CALL) || (op == OP_PUSH);
  endfunction

  // address offset from SP of access number idx
  function automatic int slot_off(op_e op, logic [SLOT_W-1:0] idx);
    case (op)
      OP_CALL, OP_PUSH: return -(int'(idx) + 1);
      OP_POP:           return int'(idx);
      default: begin
        case (idx)
          SLOT_W'(0): return 0;
          SLOT_W'(1): return 3;
          SLOT_W'(2): return 2;
          SLOT_W'(3): return 4;
          default:    return 5;
        endcase
      end
    endcase
  endfunction

  function automatic int sp_delta(op_e op);
    case (op)
      OP_CALL:          return -4;
      OP_PUSH:          return -2;
      OP_RET, OP_RETS:  return 4;
      OP_RETI:          return 6;
      OP_POP:           return 2;
      default:          return 0;
    endcase
  endfunction
endpackage

// File: rtl/nstk_sp.sv
module nstk_sp #(
  parameter int unsigned     AW      = 8,
  parameter logic [AW-1:0]   SP_INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [AW-1:0] delta,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk) begin
    if (rst)      sp <= SP_INIT;
    else if (upd) sp <= sp + delta;
  end
endmodule

// File: rtl/nstk_seq.sv
module nstk_seq
  import nstk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  op_e               cmd_op,
  output logic              accept,
  output logic              busy,
  output op_e               op_q,
  output logic [SLOT_W-1:0] cnt,
  output logic              issue,
  output logic              fin,
  output logic              rd_vld,
  output logic [SLOT_W-1:0] rd_idx
);
  logic [SLOT_W-1:0] steps;
  logic [SLOT_W-1:0] total;
  logic              wr;

  assign steps  = op_steps(op_q);
  assign wr     = op_is_write(op_q);
  assign total  = steps + SLOT_W'(!wr);
  assign accept = cmd_valid && !busy && (op_steps(cmd_op) != '0);
  assign issue  = busy && (cnt < steps);
  assign fin    = busy && (cnt == total - SLOT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      op_q   <= OP_IDLE;
      cnt    <= '0;
      rd_vld <= 1'b0;
      rd_idx <= '0;
    end else begin
      rd_vld <= issue && !wr;
      rd_idx <= cnt;
      if (accept) begin
        busy <= 1'b1;
        op_q <= cmd_op;
        cnt  <= '0;
      end else if (fin) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + SLOT_W'(1);
      end
    end
  end

  // R10: the counter never runs past the last step of the command
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= steps));
endmodule

// File: rtl/nstk_nibbuf.sv
module nstk_nibbuf #(
  parameter int SLOTS = 5,
  parameter int NW    = 4,
  parameter int IW    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap,
  input  logic [IW-1:0]      idx,
  input  logic [NW-1:0]      din,
  output logic [SLOTS*NW-1:0] view
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [NW-1:0] q;
    logic          hit;
    assign hit = cap && (idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst)      q <= '0;
      else if (hit) q <= din;
    end
    // the nibble arriving this cycle is visible at once for the final step
    assign view[g*NW +: NW] = hit ? din : q;
  end
endmodule

// File: rtl/nstk_ctrl.sv
module nstk_ctrl
  import nstk_pkg::*;
#(
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PC_W-1:0]   cmd_target,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [2*NIB_W-1:0] rp_in,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [NIB_W-1:0]  mem_wdata,
  input  logic [NIB_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     sp_out,
  output logic [PC_W-1:0]   pc_out,
  output logic              pc_load,
  output logic              skip,
  output logic [2*NIB_W-1:0] rp_out,
  output logic              rp_load,
  output logic [2*NIB_W-1:0] psw_out,
  output logic              psw_load
);
  localparam int BUF_W = MAX_SLOTS * NIB_W;

  op_e               op_q;
  logic              accept;
  logic [SLOT_W-1:0] cnt;
  logic              issue;
  logic              fin;
  logic              rd_vld;
  logic [SLOT_W-1:0] rd_idx;
  logic [BUF_W-1:0]  view;
  logic [PC_W-1:0]   tgt_q;
  logic [PC_W-1:0]   ret_q;
  logic [2*NIB_W-1:0] rp_q;
  logic [AW-1:0]     sp;

  nstk_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (op_e'(cmd_op)),
    .accept    (accept),
    .busy      (busy),
    .op_q      (op_q),
    .cnt       (cnt),
    .issue     (issue),
    .fin       (fin),
    .rd_vld    (rd_vld),
    .rd_idx    (rd_idx)
  );

  nstk_sp #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk   (clk),
    .rst   (rst),
    .upd   (fin),
    .delta (AW'(sp_delta(op_q))),
    .sp    (sp)
  );

  nstk_nibbuf #(.SLOTS(MAX_SLOTS), .NW(NIB_W), .IW(SLOT_W)) u_buf (
    .clk  (clk),
    .rst  (rst),
    .cap  (rd_vld),
    .idx  (rd_idx),
    .din  (mem_rdata),
    .view (view)
  );

  assign sp_out = sp;

  // operands captured at acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      ret_q <= '0;
      rp_q  <= '0;
    end else if (accept) begin
      tgt_q <= cmd_target;
      ret_q <= cur_pc;
      rp_q  <= rp_in;
    end
  end

  // RAM port: address from SP and the access number
  assign mem_addr = sp + AW'(slot_off(op_q, cnt));
  assign mem_we   = issue && op_is_write(op_q);

  always_comb begin
    mem_wdata = '0;
    if (op_q == OP_CALL) begin
      case (cnt)
        SLOT_W'(0): mem_wdata = ret_q[7:4];
        SLOT_W'(1): mem_wdata = ret_q[3:0];
        SLOT_W'(2): mem_wdata = '0;
        default:    mem_wdata = {1'b0, ret_q[10:8]};
      endcase
    end else if (op_q == OP_PUSH) begin
      mem_wdata = (cnt == '0) ? rp_q[7:4] : rp_q[3:0];
    end
  end

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      pc_load  <= 1'b0;
      skip     <= 1'b0;
      rp_load  <= 1'b0;
      psw_load <= 1'b0;
      pc_out   <= '0;
      rp_out   <= '0;
      psw_out  <= '0;
    end else begin
      done     <= fin;
      pc_load  <= fin && (op_q inside {OP_CALL, OP_RET, OP_RETS, OP_RETI});
      skip     <= fin && (op_q == OP_RETS);
      rp_load  <= fin && (op_q == OP_POP);
      psw_load <= fin && (op_q == OP_RETI);
      if (fin) begin
        if (op_q == OP_CALL)
          pc_out <= tgt_q;
        else if (op_q != OP_PUSH && op_q != OP_POP)
          pc_out <= {view[2:0], view[7:4], view[11:8]};
        if (op_q == OP_POP)
          rp_out <= {view[7:4], view[3:0]};
        if (op_q == OP_RETI)
          psw_out <= {view[15:12], view[19:16]};
      end
    end
  end

  // R9: SP moves by the command's step, modulo 2^AW, exactly when done appears
  p_sp_move_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (sp_out == $past(sp_out) + AW'(sp_delta(op_q))));
  // R10: done ends a busy period
  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  // R11: writes only from call or push while busy
  p_we_write_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (busy && op_is_write(op_q)));
  // R5: skip only comes with a PC load
  p_skip_pc_r5: assert property (@(posedge clk) disable iff (rst)
    skip |-> (pc_load && done));
  // R6: status word restore only with a PC restore
  p_psw_pc_r6: assert property (@(posedge clk) disable iff (rst)
    psw_load |-> (pc_load && done));
  // R8: a pop loads no PC
  p_rp_alone_r8: assert property (@(posedge clk) disable iff (rst)
    rp_load |-> (done && !pc_load && !psw_load));
endmodule

// File: tb/test_nstk_ctrl.sv
module test_nstk_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [10:0] cmd_target = '0;
  logic [10:0] cur_pc = '0;
  logic [7:0]  rp_in = '0;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [3:0]  mem_wdata;
  logic [3:0]  mem_rdata = '0;
  logic        busy, done, pc_load, skip, rp_load, psw_load;
  logic [7:0]  sp_out, rp_out, psw_out;
  logic [10:0] pc_out;

  logic [3:0] ram [0:255];
  int checks = 0;
  int failures = 0;
  int busy_cnt = 0;
  int cyc = 0;

  typedef struct {
    logic [10:0] pc; bit pcl;
    logic [7:0]  rp; bit rpl;
    logic [7:0]  psw; bit pswl;
    bit          skp;
    logic [7:0]  sp;
    int          ncyc;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [7:0] exp_sp = 8'h00;

  always #5 clk = ~clk;

  nstk_ctrl i_nstk_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cur_pc(cur_pc), .rp_in(rp_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp_out(sp_out),
    .pc_out(pc_out), .pc_load(pc_load), .skip(skip), .rp_out(rp_out),
    .rp_load(rp_load), .psw_out(psw_out), .psw_load(psw_load)
  );

  // RAM model with one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares results as done appears
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) busy_cnt++;
      if (done) begin
        if (sb.size() == 0) begin
          check(0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(busy_cnt == e.ncyc, {e.tag, " busy cycles R10"}, busy_cnt, e.ncyc);
          check(sp_out == e.sp, {e.tag, " sp R9"}, sp_out, e.sp);
          check(pc_load == e.pcl, {e.tag, " pc_load"}, pc_load, e.pcl);
          if (e.pcl) check(pc_out == e.pc, {e.tag, " pc_out"}, pc_out, e.pc);
          check(rp_load == e.rpl, {e.tag, " rp_load"}, rp_load, e.rpl);
          if (e.rpl) check(rp_out == e.rp, {e.tag, " rp_out"}, rp_out, e.rp);
          check(psw_load == e.pswl, {e.tag, " psw_load"}, psw_load, e.pswl);
          if (e.pswl) check(psw_out == e.psw, {e.tag, " psw_out"}, psw_out, e.psw);
          check(skip == e.skp, {e.tag, " skip"}, skip, e.skp);
        end
        busy_cnt = 0;
      end
    end
  end

  // driver: predicts the result, then issues the command
  task automatic run_cmd(input logic [2:0] op, input logic [10:0] tgt,
                         input logic [10:0] pc, input logic [7:0] rp,
                         input string tag, input bit poke_busy);
    exp_t e;
    logic [7:0] s;
    s = exp_sp;
    e.pc = '0; e.pcl = 0; e.rp = '0; e.rpl = 0; e.psw = '0; e.pswl = 0;
    e.skp = 0; e.tag = tag;
    case (op)
      3'd1: begin e.pc = tgt; e.pcl = 1; e.ncyc = 4; e.sp = s - 8'd4; end
      3'd2, 3'd3, 3'd4: begin
        e.pc = {ram[s][2:0], ram[8'(s + 8'd3)], ram[8'(s + 8'd2)]};
        e.pcl = 1;
        e.ncyc = (op == 3'd4) ? 6 : 4;
        e.sp = s + ((op == 3'd4) ? 8'd6 : 8'd4);
        e.skp = (op == 3'd3);
        if (op == 3'd4) begin
          e.psw = {ram[8'(s + 8'd4)], ram[8'(s + 8'd5)]};
          e.pswl = 1;
        end
      end
      3'd5: begin e.ncyc = 2; e.sp = s - 8'd2; end
      default: begin
        e.rp = {ram[8'(s + 8'd1)], ram[s]}; e.rpl = 1;
        e.ncyc = 3; e.sp = s + 8'd2;
      end
    endcase
    exp_sp = e.sp;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_target = tgt; cur_pc = pc; rp_in = rp;
    @(negedge clk);
    if (poke_busy) begin
      // R10: a push offered while busy must be ignored
      cmd_op = 3'd5; rp_in = 8'hEE;
      @(negedge clk);
    end
    cmd_valid = 0; cmd_op = 3'd0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    check(busy == 0 && done == 0, {tag, " idle after R10"}, busy, 0);
    if (op == 3'd1) begin
      check(ram[8'(s - 8'd1)] == pc[7:4], "R3 slot SP-1", ram[8'(s - 8'd1)], pc[7:4]);
      check(ram[8'(s - 8'd2)] == pc[3:0], "R3 slot SP-2", ram[8'(s - 8'd2)], pc[3:0]);
      check(ram[8'(s - 8'd3)] == 4'h0,    "R3 slot SP-3", ram[8'(s - 8'd3)], 0);
      check(ram[8'(s - 8'd4)] == {1'b0, pc[10:8]}, "R3 slot SP-4",
            ram[8'(s - 8'd4)], {1'b0, pc[10:8]});
    end
    if (op == 3'd5) begin
      check(ram[8'(s - 8'd1)] == rp[7:4], "R7 slot SP-1", ram[8'(s - 8'd1)], rp[7:4]);
      check(ram[8'(s - 8'd2)] == rp[3:0], "R7 slot SP-2", ram[8'(s - 8'd2)], rp[3:0]);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 4'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sp_out == 8'h00, "R1 sp reset", sp_out, 0);
    check(busy == 0 && done == 0 && mem_we == 0, "R1 idle in reset", busy, 0);
    rst = 0;
    @(negedge clk);
    check(sp_out == 8'h00 && busy == 0, "R1 sp after reset", sp_out, 0);
    check(pc_load == 0 && rp_load == 0 && psw_load == 0 && skip == 0,
          "R1 no loads", pc_load, 0);
    // R2: idle codes do nothing
    cmd_valid = 1; cmd_op = 3'd7; @(negedge clk);
    cmd_op = 3'd0; @(negedge clk);
    cmd_valid = 0; @(negedge clk);
    check(busy == 0 && sp_out == 8'h00, "R2 codes 0/7 ignored", sp_out, 0);
    check(done == 0, "R2 no done", done, 0);

    run_cmd(3'd1, 11'h123, 11'h5A3, 8'h00, "R3 call wrap R9", 0);
    run_cmd(3'd5, 11'h000, 11'h000, 8'hC7, "R7 push", 0);
    run_cmd(3'd6, 11'h000, 11'h000, 8'h00, "R8 pop", 0);
    run_cmd(3'd2, 11'h000, 11'h000, 8'h00, "R4 ret", 0);
    run_cmd(3'd1, 11'h400, 11'h7FF, 8'h00, "R3 call high", 0);
    ram[exp_sp] = ram[exp_sp] | 4'h8;   // R4: stray top bit must be dropped
    run_cmd(3'd3, 11'h000, 11'h000, 8'h00, "R5 retskip", 0);
    run_cmd(3'd1, 11'h0AB, 11'h2C9, 8'h00, "R10 call ignore", 1);
    check(sp_out == 8'hFC, "R10 push while busy ignored", sp_out, 8'hFC);
    ram[8'hFC] = 4'h2; ram[8'hFF] = 4'h7; ram[8'hFE] = 4'h4;
    ram[8'h00] = 4'hB; ram[8'h01] = 4'h6;
    run_cmd(3'd4, 11'h000, 11'h000, 8'h00, "R6 reti wrap R9", 0);
    check(sp_out == 8'h02, "R6 sp after reti", sp_out, 2);
    check(mem_we == 0, "R11 no write idle", mem_we, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule